// File: doc/BRIEF.md
# Core Idle-State Sequencer

This block follows one processor core through its idle states: active (C0), light halt (C1), and the two deep sleep states C3 and C6. The core asks to sleep in one of two ways. It can issue an I/O-read trigger carrying a level bit, or a wait request carrying a two-bit hint. A light halt keeps the core clock running, and snoops are still answered while halted.

A deep request first sends the core's private caches through a flush handshake. The sequencer raises a flush request and holds it until the cache side answers with a done pulse. Only then does it stop the core clock. In a deep state, snoops and other threads' cacheable accesses are absorbed: the cache holds no data, so nothing wakes the core.

An interrupt brings the core back to C0 from any idle state. A system-management entry runs the core active and, on exit, returns it to C0 or C1, whichever it held before. A synchronous reset forces C0 from anywhere.

Top module: `core_idle_ctrl`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `cstate` is 0, `clk_en` is 1, and `flush_req` and `snoop_svc` are 0.
- R2: In C0, a wait request with hint 0 moves `cstate` to 1 (C1) one cycle later, and `clk_en` stays 1.
- R3: A `snoop` pulse while the core is in C0 or C1 raises `snoop_svc` for one cycle, one cycle later, and leaves `cstate` unchanged.
- R4: The state codes are C0=0, C1=1, C3=3 and C6=6. A trigger with level bit 0, or a wait request with hint 1, targets C3. A trigger with level bit 1, or a wait hint of 2 or 3, targets C6. A trigger takes precedence over a wait request in the same cycle.
- R5: A deep request in C0 raises `flush_req` one cycle later. While the flush is in progress, `cstate` stays 0 and `clk_en` stays 1.
- R6: `flush_done` during a flush drops `flush_req` one cycle later. In that same cycle, `cstate` takes the target code and `clk_en` falls to 0.
- R7: In C3 or C6, a `snoop` pulse changes no output: `cstate` is unchanged, `clk_en` stays 0 and `snoop_svc` stays 0.
- R8: `irq` in C1, C3 or C6 makes `cstate` 0 and `clk_en` 1 one cycle later.
- R9: An `irq` during a flush, including in the cycle of `flush_done`, aborts the entry. After `flush_done`, the core is in C0 with `clk_en` still 1.
- R10: `irq` in the same cycle as a sleep request in C0 cancels the request, so the state stays C0 with no flush.
- R11: `smi_req` in C0, C1, C3 or C6 makes `cstate` 0 with `clk_en` 1, and has priority over `irq`. Until `smi_done`, `irq` has no effect. `smi_done` returns the core to C1 if it was in C1 before the management entry, and to C0 otherwise.
- R12: Sleep requests are ignored in any state other than C0.
- R13: Reset returns the core to C0 from a flush or from a deep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | I/O-read sleep trigger |
| trig_level | input | 1 | Trigger level: 0 selects C3, 1 selects C6 |
| wait_valid | input | 1 | Wait-instruction sleep request |
| wait_hint | input | 2 | Target hint: 0 C1, 1 C3, 2 or 3 C6 |
| irq | input | 1 | Interrupt wake |
| snoop | input | 1 | Snoop or cross-thread cacheable access |
| flush_done | input | 1 | Private-cache flush complete |
| smi_req | input | 1 | System-management entry |
| smi_done | input | 1 | System-management handler finished |
| cstate | output | 3 | Current state code |
| clk_en | output | 1 | Core clock enable |
| flush_req | output | 1 | Private-cache flush request |
| snoop_svc | output | 1 | Snoop serviced by the running core |

## Verification
The hardest situation to reach is an interrupt that lands inside the flush window. The entry must then be aborted, yet the handshake must still be allowed to finish. The stimulus holds `flush_done` off for a cycle after the interrupt so that the latched abort is what decides the outcome. It also covers the tighter case where the interrupt and the done pulse share a single cycle. Returning to C1 from a management entry needs the core parked in C1 first, with an interrupt offered during the handler to show that it is held off.

// File: rtl/cidle_pkg.sv
package cidle_pkg;
  localparam int CODE_W = 3;
  localparam int HINT_W = 2;

  localparam logic [CODE_W-1:0] CODE_C0 = 3'd0;
  localparam logic [CODE_W-1:0] CODE_C1 = 3'd1;
  localparam logic [CODE_W-1:0] CODE_C3 = 3'd3;
  localparam logic [CODE_W-1:0] CODE_C6 = 3'd6;

  typedef enum logic [2:0] {
    PH_C0, PH_C1, PH_FLUSH, PH_C3, PH_C6, PH_SMM
  } phase_t;

  function automatic logic [CODE_W-1:0] code_of(phase_t p);
    case (p)
      PH_C1:   return CODE_C1;
      PH_C3:   return CODE_C3;
      PH_C6:   return CODE_C6;
      default: return CODE_C0;
    endcase
  endfunction
endpackage

// File: rtl/cidle_req_decode.sv
module cidle_req_decode
  import cidle_pkg::*;
#(
  parameter int HW = HINT_W
) (
  input  logic          trig_valid,
  input  logic          trig_level,
  input  logic          wait_valid,
  input  logic [HW-1:0] wait_hint,
  output logic          light_req,
  output logic          deep_req,
  output logic          deep_is_c6
);
  localparam logic [HW-1:0] HINT_C1 = '0;
  localparam logic [HW-1:0] HINT_C3 = HW'(1);

  always_comb begin
    light_req  = 1'b0;
    deep_req   = 1'b0;
    deep_is_c6 = 1'b0;
    if (trig_valid) begin
      deep_req   = 1'b1;
      deep_is_c6 = trig_level;
    end else if (wait_valid) begin
      if (wait_hint == HINT_C1) begin
        light_req = 1'b1;
      end else begin
        deep_req   = 1'b1;
        deep_is_c6 = (wait_hint != HINT_C3);
      end
    end
  end
endmodule

// File: rtl/cidle_seq.sv
module cidle_seq
  import cidle_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          light_req,
  input  logic          deep_req,
  input  logic          deep_is_c6,
  input  logic          irq,
  input  logic          flush_done,
  input  logic          smi_req,
  input  logic          smi_done,
  output logic [CW-1:0] cstate,
  output logic          clk_en,
  output logic          flush_req
);
  phase_t phase_q, phase_d;
  logic   tgt_c6_q, tgt_c6_d;
  logic   abort_q, abort_d;
  logic   ret_c1_q, ret_c1_d;

  always_comb begin
    phase_d  = phase_q;
    tgt_c6_d = tgt_c6_q;
    abort_d  = abort_q;
    ret_c1_d = ret_c1_q;
    case (phase_q)
      PH_C0: begin
        if (smi_req) begin
          phase_d  = PH_SMM;
          ret_c1_d = 1'b0;
        end else if (!irq) begin
          if (deep_req) begin
            phase_d  = PH_FLUSH;
            tgt_c6_d = deep_is_c6;
            abort_d  = 1'b0;
          end else if (light_req) begin
            phase_d = PH_C1;
          end
        end
      end
      PH_C1: begin
        if (smi_req) begin
          phase_d  = PH_SMM;
          ret_c1_d = 1'b1;
        end else if (irq) begin
          phase_d = PH_C0;
        end
      end
      PH_FLUSH: begin
        abort_d = abort_q | irq;
        if (flush_done) begin
          abort_d = 1'b0;
          if (abort_q | irq) phase_d = PH_C0;
          else               phase_d = tgt_c6_q ? PH_C6 : PH_C3;
        end
      end
      PH_C3, PH_C6: begin
        if (smi_req) begin
          phase_d  = PH_SMM;
          ret_c1_d = 1'b0;
        end else if (irq) begin
          phase_d = PH_C0;
        end
      end
      PH_SMM: begin
        if (smi_done) phase_d = ret_c1_q ? PH_C1 : PH_C0;
      end
      default: phase_d = PH_C0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_C0;
      tgt_c6_q  <= 1'b0;
      abort_q   <= 1'b0;
      ret_c1_q  <= 1'b0;
      cstate    <= CODE_C0;
      clk_en    <= 1'b1;
      flush_req <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      tgt_c6_q  <= tgt_c6_d;
      abort_q   <= abort_d;
      ret_c1_q  <= ret_c1_d;
      cstate    <= code_of(phase_d);
      clk_en    <= !(phase_d == PH_C3 || phase_d == PH_C6);
      flush_req <= (phase_d == PH_FLUSH);
    end
  end
endmodule

// File: rtl/cidle_snoop.sv
module cidle_snoop (
  input  logic clk,
  input  logic rst,
  input  logic snoop,
  input  logic core_running,
  output logic snoop_svc
);
  always_ff @(posedge clk) begin
    if (rst) snoop_svc <= 1'b0;
    else     snoop_svc <= snoop & core_running;
  end
endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl
  import cidle_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_valid,
  input  logic              trig_level,
  input  logic              wait_valid,
  input  logic [HINT_W-1:0] wait_hint,
  input  logic              irq,
  input  logic              snoop,
  input  logic              flush_done,
  input  logic              smi_req,
  input  logic              smi_done,
  output logic [CODE_W-1:0] cstate,
  output logic              clk_en,
  output logic              flush_req,
  output logic              snoop_svc
);
  logic light_req, deep_req, deep_is_c6;

  cidle_req_decode #(.HW(HINT_W)) u_dec (
    .trig_valid (trig_valid),
    .trig_level (trig_level),
    .wait_valid (wait_valid),
    .wait_hint  (wait_hint),
    .light_req  (light_req),
    .deep_req   (deep_req),
    .deep_is_c6 (deep_is_c6)
  );

  cidle_seq #(.CW(CODE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .light_req  (light_req),
    .deep_req   (deep_req),
    .deep_is_c6 (deep_is_c6),
    .irq        (irq),
    .flush_done (flush_done),
    .smi_req    (smi_req),
    .smi_done   (smi_done),
    .cstate     (cstate),
    .clk_en     (clk_en),
    .flush_req  (flush_req)
  );

  cidle_snoop u_snp (
    .clk          (clk),
    .rst          (rst),
    .snoop        (snoop),
    .core_running (clk_en),
    .snoop_svc    (snoop_svc)
  );
endmodule

// File: rtl/cidle_chk.sv
module cidle_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       smi_req,
  input logic       flush_done,
  input logic [2:0] cstate,
  input logic       clk_en,
  input logic       flush_req,
  input logic       snoop_svc
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cstate == 3'd0 && clk_en && !flush_req && !snoop_svc));

  assert_legal_code_R4: assert property (@(posedge clk) disable iff (rst)
    (cstate == 3'd0 || cstate == 3'd1 || cstate == 3'd3 || cstate == 3'd6));

  assert_clock_during_flush_R5: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> clk_en);

  assert_gate_after_flush_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en) |-> $past(flush_req && flush_done));

  assert_snoop_absorbed_R7: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && !irq && !smi_req) |=> ($stable(cstate) && !snoop_svc && !clk_en));

  assert_irq_wake_R8: assert property (@(posedge clk) disable iff (rst)
    (!clk_en && irq) |=> (cstate == 3'd0 && clk_en));
endmodule

bind core_idle_ctrl cidle_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .smi_req    (smi_req),
  .flush_done (flush_done),
  .cstate     (cstate),
  .clk_en     (clk_en),
  .flush_req  (flush_req),
  .snoop_svc  (snoop_svc)
);

// File: tb/core_idle_ctrl_tb.sv
module core_idle_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig_valid = 0, trig_level = 0, wait_valid = 0;
  logic [1:0] wait_hint = 0;
  logic       irq = 0, snoop = 0, flush_done = 0, smi_req = 0, smi_done = 0;
  logic [2:0] cstate;
  logic       clk_en, flush_req, snoop_svc;

  typedef struct {
    logic [2:0] st;
    logic       ce;
    logic       fr;
    logic       sv;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  always #4 clk = ~clk;

  core_idle_ctrl u_dut (
    .clk(clk), .rst(rst), .trig_valid(trig_valid), .trig_level(trig_level),
    .wait_valid(wait_valid), .wait_hint(wait_hint), .irq(irq), .snoop(snoop),
    .flush_done(flush_done), .smi_req(smi_req), .smi_done(smi_done),
    .cstate(cstate), .clk_en(clk_en), .flush_req(flush_req), .snoop_svc(snoop_svc)
  );

  task automatic tick(input logic [2:0] st, input logic ce, input logic fr,
                      input logic sv, input string tag);
    exp_t e;
    e.st = st; e.ce = ce; e.fr = fr; e.sv = sv; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    rst = 0; trig_valid = 0; trig_level = 0; wait_valid = 0; wait_hint = 0;
    irq = 0; snoop = 0; flush_done = 0; smi_req = 0; smi_done = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (cstate !== e.st || clk_en !== e.ce || flush_req !== e.fr || snoop_svc !== e.sv) begin
        errors++;
        $display("FAIL %s: got st=%0d ce=%0b fr=%0b sv=%0b, expected st=%0d ce=%0b fr=%0b sv=%0b",
                 e.tag, cstate, clk_en, flush_req, snoop_svc, e.st, e.ce, e.fr, e.sv);
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; tick(0, 1, 0, 0, "R1 reset");
    rst = 1; snoop = 1; tick(0, 1, 0, 0, "R1 reset holds");
    snoop = 1; tick(0, 1, 0, 1, "R3 snoop in C0");
    wait_valid = 1; wait_hint = 0; tick(1, 1, 0, 0, "R2 enter C1");
    snoop = 1; tick(1, 1, 0, 1, "R3 snoop in C1");
    trig_valid = 1; trig_level = 1; tick(1, 1, 0, 0, "R12 trigger in C1 ignored");
    irq = 1; tick(0, 1, 0, 0, "R8 wake from C1");
    // level-2 trigger -> C3
    trig_valid = 1; trig_level = 0; tick(0, 1, 1, 0, "R5 flush request");
    tick(0, 1, 1, 0, "R5 flush held");
    flush_done = 1; tick(3, 0, 0, 0, "R6 enter C3");
    snoop = 1; tick(3, 0, 0, 0, "R7 snoop absorbed in C3");
    wait_valid = 1; wait_hint = 2; tick(3, 0, 0, 0, "R12 wait in C3 ignored");
    irq = 1; tick(0, 1, 0, 0, "R8 wake from C3");
    // wait hint 3 -> C6
    wait_valid = 1; wait_hint = 3; tick(0, 1, 1, 0, "R4 hint 3 flush");
    flush_done = 1; tick(6, 0, 0, 0, "R4 hint 3 gives C6");
    snoop = 1; tick(6, 0, 0, 0, "R7 snoop absorbed in C6");
    irq = 1; tick(0, 1, 0, 0, "R8 wake from C6");
    // wait hint 1 -> C3
    wait_valid = 1; wait_hint = 1; tick(0, 1, 1, 0, "R4 hint 1 flush");
    flush_done = 1; tick(3, 0, 0, 0, "R4 hint 1 gives C3");
    irq = 1; tick(0, 1, 0, 0, "R8 wake");
    // trigger beats wait
    trig_valid = 1; trig_level = 1; wait_valid = 1; wait_hint = 1;
    tick(0, 1, 1, 0, "R4 trigger precedence flush");
    flush_done = 1; tick(6, 0, 0, 0, "R4 trigger precedence gives C6");
    irq = 1; tick(0, 1, 0, 0, "R8 wake");
    // irq during flush
    trig_valid = 1; tick(0, 1, 1, 0, "R9 flush start");
    irq = 1; tick(0, 1, 1, 0, "R9 irq latched");
    flush_done = 1; tick(0, 1, 0, 0, "R9 aborted to C0");
    trig_valid = 1; tick(0, 1, 1, 0, "R9 flush start");
    flush_done = 1; irq = 1; tick(0, 1, 0, 0, "R9 irq with done aborts");
    trig_valid = 1; irq = 1; tick(0, 1, 0, 0, "R10 irq cancels entry");
    // management entry from C1
    wait_valid = 1; wait_hint = 0; tick(1, 1, 0, 0, "R2 enter C1");
    smi_req = 1; irq = 1; tick(0, 1, 0, 0, "R11 smi from C1");
    irq = 1; tick(0, 1, 0, 0, "R11 irq held off in handler");
    smi_done = 1; tick(1, 1, 0, 0, "R11 return to C1");
    irq = 1; tick(0, 1, 0, 0, "R8 wake");
    smi_req = 1; tick(0, 1, 0, 0, "R11 smi from C0");
    smi_done = 1; tick(0, 1, 0, 0, "R11 return to C0");
    // management entry from C6
    trig_valid = 1; trig_level = 1; tick(0, 1, 1, 0, "R5 flush");
    flush_done = 1; tick(6, 0, 0, 0, "R6 enter C6");
    smi_req = 1; irq = 1; tick(0, 1, 0, 0, "R11 smi from C6");
    smi_done = 1; tick(0, 1, 0, 0, "R11 deep returns to C0");
    // reset from flush and from deep
    trig_valid = 1; tick(0, 1, 1, 0, "R5 flush");
    rst = 1; tick(0, 1, 0, 0, "R13 reset during flush");
    trig_valid = 1; tick(0, 1, 1, 0, "R5 flush");
    flush_done = 1; tick(3, 0, 0, 0, "R6 enter C3");
    rst = 1; tick(0, 1, 0, 0, "R13 reset from C3");
    tick(0, 1, 0, 0, "R1 idle after reset");
    @(posedge clk);
    #2;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule